// File: doc/BRIEF.md
# Mixed-Polarity Interrupt Controller

This block gathers nine dedicated external interrupt pins and an 8-bit general-purpose input port and turns them into two active-high processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Every input is first passed through a two-flop synchronizer. Each dedicated pin then has its own fixed sensitivity: falling edge, rising edge, active-low level or active-high level. Edge events are held in sticky status bits, and level sources show their live synchronized state.

Two mask registers decide which pending sources reach which output. Each source also has a fixed routing capability. Some sources can only raise the normal request, one can only raise the fast request, and three can be steered to either output. Mask bits that a source is not allowed to use cannot be set. Software uses a small register bus to read status and the synchronized pin levels, to program the masks, and to clear sticky edge bits by writing ones. Both request outputs and the read data are registered.

Source numbering used throughout: bits 0..8 are the dedicated pins `ext_pin_i[0..8]`, and bits 9..16 are `gpio_i[0..7]`.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: After synchronous reset, both mask registers read 0, the sticky edge bits are 0, and `irq_o`, `fiq_o` and `reg_rdata_o` are 0.
- R2: Source 0 sets its sticky status bit (status bit 0) on a falling edge of `ext_pin_i[0]`. A rising edge on that pin sets nothing. Once set, the bit stays set until it is cleared.
- R3: Source 1 sets its sticky status bit (status bit 1) on a rising edge of `ext_pin_i[1]`. A falling edge on that pin sets nothing.
- R4: Level sources show their live synchronized state in status. Bits 2, 3, 5 and 7 are active low. Bits 4, 6 and 8 are active high. Port bits 9..16 are active high.
- R5: Writing to the clear register (address 1) clears each sticky bit whose data bit is 1, and leaves every bit written 0 unchanged. Level bits are not affected by a clear. When an edge and a clear of the same bit land in the same cycle, the bit ends up set.
- R6: Writable IRQ-mask bits are 0..7 and 9..16 (value 0x1FEFF). Writable FIQ-mask bits are 4, 5, 7 and 8 (value 0x1B0). All other mask bits always read 0. The IRQ mask is at address 2 and the FIQ mask is at address 3.
- R7: `irq_o` is the registered OR of the status bits that are set in the IRQ mask and clear in the FIQ mask.
- R8: `fiq_o` is the registered OR of the status bits that are set in the FIQ mask.
- R9: A steerable source that is enabled in both masks raises only `fiq_o`.
- R10: Address 4 reads the synchronized raw levels: bits 8..0 are `ext_pin_i`, and bits 16..9 are `gpio_i`. Bit 0 gives the level of the falling-edge pin.
- R11: Read data appears one cycle after the address. Address 0 returns status. Address 1 and addresses 5..7 read 0.
- R12: Each pin reaches status only through two synchronizer flops, so a level change shows in status two cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 9 | Dedicated interrupt pins, sources 0..8 |
| gpio_i | input | PORT_W (8) | General-purpose port, sources 9..16 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (3) | Register address |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
Several rules are checked by assertions on every cycle:
- the mask registers never hold a bit outside the routing capability;
- no request is raised one cycle after status is empty;
- a fast request always has a masked pending source behind it;
- a sticky bit stays set unless a matching clear is written;
- level status tracks the pins with a two-cycle delay.

Other behaviours can only be shown by the bench's scenarios. These are the polarity of each edge source, the clear-and-set collision, the FIQ precedence when a source is enabled in both masks, and the agreement of status and request outputs with a reference model over random pin and mask sequences.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_EXT = 9;

  // Fixed per-pin behaviour of the dedicated pins (bit i = source i)
  localparam logic [N_EXT-1:0] EXT_FALL    = 9'b0_0000_0001;
  localparam logic [N_EXT-1:0] EXT_RISE    = 9'b0_0000_0010;
  localparam logic [N_EXT-1:0] EXT_ACT_LOW = 9'b0_1010_1100;
  localparam logic [N_EXT-1:0] EXT_IDLE    = 9'b0_1010_1101;
  localparam logic [N_EXT-1:0] EXT_IRQ_CAP = 9'b0_1111_1111;
  localparam logic [N_EXT-1:0] EXT_FIQ_CAP = 9'b1_1011_0000;

  // Register map
  localparam int A_STATUS = 0;
  localparam int A_CLEAR  = 1;
  localparam int A_IMASK  = 2;
  localparam int A_FMASK  = 3;
  localparam int A_RAW    = 4;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= IDLE;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int W = 1,
  parameter logic [W-1:0] FALL = '0,
  parameter logic [W-1:0] RISE = '0,
  parameter logic [W-1:0] ACT_LOW = '0,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_src
    if (FALL[b] || RISE[b]) begin : g_edge
      logic hit;
      logic sticky;
      assign hit = FALL[b] ? (prev[b] & ~lvl_i[b]) : (~prev[b] & lvl_i[b]);
      // a new edge wins over a clear in the same cycle
      always_ff @(posedge clk) begin
        if (rst)           sticky <= 1'b0;
        else if (hit)      sticky <= 1'b1;
        else if (clr_i[b]) sticky <= 1'b0;
      end
      assign pend_o[b] = sticky;
    end else begin : g_level
      assign pend_o[b] = lvl_i[b] ^ ACT_LOW[b];
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NS = 17,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [NS-1:0] IRQ_CAP = '1,
  parameter logic [NS-1:0] FIQ_CAP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NS-1:0]     pend_i,
  input  logic [NS-1:0]     raw_i,
  output logic [NS-1:0]     irq_msk_o,
  output logic [NS-1:0]     fiq_msk_o,
  output logic [NS-1:0]     clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_nxt;
  logic sel_clr, sel_im, sel_fm;

  assign sel_clr = (addr_i == ADDR_W'(A_CLEAR));
  assign sel_im  = (addr_i == ADDR_W'(A_IMASK));
  assign sel_fm  = (addr_i == ADDR_W'(A_FMASK));

  assign clr_o = (wr_i && sel_clr) ? wdata_i[NS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_msk_o <= '0;
      fiq_msk_o <= '0;
    end else if (wr_i) begin
      if (sel_im) irq_msk_o <= wdata_i[NS-1:0] & IRQ_CAP;
      if (sel_fm) fiq_msk_o <= wdata_i[NS-1:0] & FIQ_CAP;
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (addr_i)
      ADDR_W'(A_STATUS): rd_nxt[NS-1:0] = pend_i;
      ADDR_W'(A_IMASK):  rd_nxt[NS-1:0] = irq_msk_o;
      ADDR_W'(A_FMASK):  rd_nxt[NS-1:0] = fiq_msk_o;
      ADDR_W'(A_RAW):    rd_nxt[NS-1:0] = raw_i;
      default:           rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int NS = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] pend_i,
  input  logic [NS-1:0] irq_msk_i,
  input  logic [NS-1:0] fiq_msk_i,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [NS-1:0] to_irq, to_fiq;

  // the fast path takes precedence for a source enabled in both masks
  assign to_fiq = pend_i & fiq_msk_i;
  assign to_irq = pend_i & irq_msk_i & ~fiq_msk_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |to_irq;
      fiq_o <= |to_fiq;
    end
  end
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
  import intc_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [PORT_W-1:0] gpio_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NS = N_EXT + PORT_W;
  localparam logic [NS-1:0] IDLE_V  = {{PORT_W{1'b0}}, EXT_IDLE};
  localparam logic [NS-1:0] FALL_V  = {{PORT_W{1'b0}}, EXT_FALL};
  localparam logic [NS-1:0] RISE_V  = {{PORT_W{1'b0}}, EXT_RISE};
  localparam logic [NS-1:0] LOW_V   = {{PORT_W{1'b0}}, EXT_ACT_LOW};
  localparam logic [NS-1:0] IRQ_CAP = {{PORT_W{1'b1}}, EXT_IRQ_CAP};
  localparam logic [NS-1:0] FIQ_CAP = {{PORT_W{1'b0}}, EXT_FIQ_CAP};

  logic [NS-1:0] raw_sync, pend, clr, irq_msk, fiq_msk;

  intc_sync #(.W(NS), .STAGES(SYNC_STAGES), .IDLE(IDLE_V)) sync_i (
    .clk(clk), .rst(rst), .d_i({gpio_i, ext_pin_i}), .q_o(raw_sync)
  );

  intc_detect #(.W(NS), .FALL(FALL_V), .RISE(RISE_V), .ACT_LOW(LOW_V), .IDLE(IDLE_V)) det_i (
    .clk(clk), .rst(rst), .lvl_i(raw_sync), .clr_i(clr), .pend_o(pend)
  );

  intc_regs #(.NS(NS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
              .IRQ_CAP(IRQ_CAP), .FIQ_CAP(FIQ_CAP)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend), .raw_i(raw_sync),
    .irq_msk_o(irq_msk), .fiq_msk_o(fiq_msk), .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  intc_route #(.NS(NS)) route_i (
    .clk(clk), .rst(rst), .pend_i(pend), .irq_msk_i(irq_msk),
    .fiq_msk_i(fiq_msk), .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/mixed_irq_ctrl_chk.sv
module mixed_irq_ctrl_chk #(
  parameter int NS = 17,
  parameter int PORT_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [NS-1:0] IRQ_CAP = '1,
  parameter logic [NS-1:0] FIQ_CAP = '0,
  parameter logic [8:0] ACT_LOW = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [8:0]        ext_pin_i,
  input logic [PORT_W-1:0] gpio_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NS-1:0]     pend,
  input logic [NS-1:0]     irq_msk,
  input logic [NS-1:0]     fiq_msk
);
  logic [1:0] cyc;
  logic [8:0] ext_d1, ext_d2;
  logic [PORT_W-1:0] gp_d1, gp_d2;
  logic clr0, clr1;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    ext_d1 <= ext_pin_i;
    ext_d2 <= ext_d1;
    gp_d1  <= gpio_i;
    gp_d2  <= gp_d1;
  end

  assign clr0 = reg_wr_i && (reg_addr_i == ADDR_W'(1)) && reg_wdata_i[0];
  assign clr1 = reg_wr_i && (reg_addr_i == ADDR_W'(1)) && reg_wdata_i[1];

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && reg_rdata_o == '0));

  p_mask_cap_r6: assert property (@(posedge clk) disable iff (rst)
    ((irq_msk & ~IRQ_CAP) == '0) && ((fiq_msk & ~FIQ_CAP) == '0));

  p_idle_outputs_r7: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (!irq_o && !fiq_o));

  p_fiq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past((pend & fiq_msk) != '0));

  p_fiq_precedence_r9: assert property (@(posedge clk) disable iff (rst)
    ((pend & irq_msk & ~fiq_msk) == '0) |=> !irq_o);

  p_sticky_hold0_r5: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !clr0) |=> pend[0]);

  p_sticky_hold1_r5: assert property (@(posedge clk) disable iff (rst)
    (pend[1] && !clr1) |=> pend[1]);

  p_sync_delay_r12: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> ((pend[8:2] == (ext_d2[8:2] ^ ACT_LOW[8:2])) &&
                       (pend[NS-1:9] == gp_d2)));

  p_unused_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADDR_W'(1) || reg_addr_i > ADDR_W'(4)) |=> (reg_rdata_o == '0));
endmodule

bind mixed_irq_ctrl mixed_irq_ctrl_chk #(
  .NS(NS), .PORT_W(PORT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .IRQ_CAP(IRQ_CAP), .FIQ_CAP(FIQ_CAP), .ACT_LOW(intc_pkg::EXT_ACT_LOW)
) chk_i (
  .clk(clk), .rst(rst), .ext_pin_i(ext_pin_i), .gpio_i(gpio_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .pend(pend), .irq_msk(irq_msk), .fiq_msk(fiq_msk)
);

// File: tb/mixed_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mixed_irq_ctrl_tb_top;
  localparam logic [8:0]  IDLE    = 9'b0_1010_1101;
  localparam logic [8:0]  LOWACT  = 9'b0_1010_1100;
  localparam logic [16:0] ICAP    = 17'h1FEFF;
  localparam logic [16:0] FCAP    = 17'h001B0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] ext_pin = IDLE;
  logic [7:0] gpio = 8'h00;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0]  m_sticky = 2'b00;
  logic [16:0] m_im = '0;
  logic [16:0] m_fm = '0;

  always #2 clk = ~clk;

  mixed_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .gpio_i(gpio),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [16:0] exp_status();
    logic [16:0] s;
    s = {gpio, ext_pin ^ LOWACT};
    s[1:0] = m_sticky;
    return s;
  endfunction

  function automatic logic exp_irq(logic [16:0] s);
    return |(s & m_im & ~m_fm);
  endfunction

  function automatic logic exp_fiq(logic [16:0] s);
    return |(s & m_fm);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd1) m_sticky = m_sticky & ~d[1:0];
    if (a == 3'd2) m_im = d[16:0] & ICAP;
    if (a == 3'd3) m_fm = d[16:0] & FCAP;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pins(logic [8:0] e, logic [7:0] g);
    if (ext_pin[0] && !e[0]) m_sticky[0] = 1'b1;
    if (!ext_pin[1] && e[1]) m_sticky[1] = 1'b1;
    @(negedge clk);
    ext_pin = e; gpio = g;
    tick(6);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    logic [16:0] s;
    rd(3'd0, d);
    s = exp_status();
    chk(req, d, {15'd0, s});
    chk(req, {31'd0, irq}, {31'd0, exp_irq(s)});
    chk(req, {31'd0, fiq}, {31'd0, exp_fiq(s)});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20250611));
    tick(4);
    rst = 1'b0;
    tick(4);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 fiq", {31'd0, fiq}, 32'd0);
    rd(3'd2, d); chk("R1 irq mask", d, 32'd0);
    rd(3'd3, d); chk("R1 fiq mask", d, 32'd0);
    check_all("R1 status");

    // R10 raw levels
    rd(3'd4, d); chk("R10 raw idle", d, {23'd0, 8'h00, IDLE});
    pins(IDLE, 8'hA5);
    rd(3'd4, d); chk("R10 raw port", d, {15'd0, 8'hA5, IDLE});
    pins(IDLE, 8'h00);

    // R2 falling edge on source 0, rising edge ignored
    pins(IDLE & ~9'b1, 8'h00);
    check_all("R2 fall sets");
    rd(3'd4, d); chk("R10 pin0 level", {31'd0, d[0]}, 32'd0);
    wr(3'd1, 32'h1); tick(1);
    pins(IDLE, 8'h00);
    check_all("R2 rise ignored");

    // R3 rising edge on source 1
    pins(IDLE | 9'b10, 8'h00);
    check_all("R3 rise sets");
    pins(IDLE, 8'h00);
    check_all("R3 fall ignored keeps sticky");

    // R5 clear: zero bits untouched, one bits clear
    wr(3'd1, 32'h0); tick(1);
    check_all("R5 clear zero no effect");
    wr(3'd1, 32'h3); tick(1);
    check_all("R5 clear ones");

    // R4 levels: all asserted
    pins(~IDLE & ~9'b11 | 9'b01, 8'hFF);
    check_all("R4 all levels active");
    wr(3'd1, 32'h1FFFC); tick(1);
    check_all("R5 clear leaves levels");
    pins(IDLE, 8'h00);
    check_all("R4 all levels idle");

    // R6 capability
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd2, d); chk("R6 irq cap", d, 32'h1FEFF);
    wr(3'd3, 32'hFFFFFFFF);
    rd(3'd3, d); chk("R6 fiq cap", d, 32'h001B0);

    // R9 source 4 enabled in both masks
    pins(IDLE | 9'h010, 8'h00);
    chk("R9 irq", {31'd0, irq}, 32'd0);
    chk("R9 fiq", {31'd0, fiq}, 32'd1);
    // R7 with fiq mask cleared
    wr(3'd3, 32'h0); tick(2);
    chk("R7 irq", {31'd0, irq}, 32'd1);
    chk("R7 fiq", {31'd0, fiq}, 32'd0);
    // R8 source 8 fiq only
    wr(3'd2, 32'h0);
    pins(IDLE | 9'h100, 8'h00);
    wr(3'd3, 32'h100); tick(2);
    chk("R8 fiq", {31'd0, fiq}, 32'd1);
    chk("R8 irq", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h0);
    pins(IDLE, 8'h00);

    // R5 collision: falling edge and clear in same cycle
    @(negedge clk); ext_pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1;
    @(negedge clk); reg_wr = 1'b0;
    m_sticky[0] = 1'b1;
    tick(3);
    check_all("R5 set wins collision");
    wr(3'd1, 32'h1);
    pins(IDLE, 8'h00);

    // R11 unused addresses
    rd(3'd1, d); chk("R11 clear reads 0", d, 32'd0);
    rd(3'd6, d); chk("R11 unused reads 0", d, 32'd0);

    // R12 two-stage synchronizer latency on a level pin (bit 6, active high)
    @(negedge clk); ext_pin[6] = 1'b1; reg_addr = 3'd0;
    @(negedge clk); chk("R12 not yet", {31'd0, reg_rdata[6]}, 32'd0);
    @(negedge clk); chk("R12 not yet 2", {31'd0, reg_rdata[6]}, 32'd0);
    @(negedge clk); chk("R12 visible", {31'd0, reg_rdata[6]}, 32'd1);
    pins(IDLE, 8'h00);

    // random phase: R2 R3 R4 R7 R8 R9
    for (int it = 0; it < 400; it++) begin
      logic [8:0] e;
      logic [7:0] g;
      e = IDLE ^ (9'($urandom) & 9'($urandom));
      g = 8'($urandom) & 8'($urandom);
      if (($urandom % 4) == 0) wr(3'd2, $urandom);
      if (($urandom % 4) == 0) wr(3'd3, $urandom);
      if (($urandom % 3) == 0) begin wr(3'd1, $urandom); tick(1); end
      pins(e, g);
      check_all("R7 R8 R9 R4 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule